// File: doc/BRIEF.md
# Random Byte Register Window

This block puts a random byte source behind a window of four byte addresses, three of them mapped, on a simple byte-wide register bus. Software reads a control byte holding a read-only "generator fitted" flag and a writable on/off bit. It polls a ready flag as often as it likes, then fetches one random byte. The byte source is an external stream of bytes with a valid strobe. In this project a linear feedback shift register stands in for it.

The block holds exactly one byte. While the block is switched on and the slot is empty, the first valid byte from the source is latched and the ready flag rises. Reading the data address hands the byte out and empties the slot. Switching off empties the slot, zeroes the byte and stops all capture. Read data is registered: it appears on the cycle after the read strobe and holds until the next read.

Top module: `rng_regwin`

## Requirements
- R1: Address 0 reads the control byte, address 1 reads {7'b0, ready}, address 2 reads the held byte, address 3 reads 0x00. The value appears on `bus_rdata` one cycle after `bus_re` and holds while `bus_re` is low.
- R2: Bit 6 of the control byte always reads 1, whatever is written.
- R3: A write to address 0 sets the on/off flag (control bit 0) from `bus_wdata[0]` and ignores the other bits. A later read of address 0 returns the new value, so an enabled block reads 0x41 and a disabled one 0x40.
- R4: While on and not ready, a cycle with `ent_valid` high latches `ent_byte` and sets ready, visible from the next cycle.
- R5: While ready, further source bytes are ignored and the held byte does not change.
- R6: Reading address 0 or 1 changes neither the ready flag nor the held byte, however many times it is done.
- R7: A read of address 2 returns the held byte and clears ready. A source byte arriving in that same cycle is dropped. The held byte is kept, so a second read of address 2 returns it again with ready still 0.
- R8: While off, no byte is captured and ready stays 0. Writing 0 to the on/off flag clears ready and zeroes the held byte.
- R9: Writes to addresses 1, 2 and 3 change nothing.
- R10: After reset the block is off, not ready, the held byte is 0x00 and `bus_rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| ent_valid | input | 1 | Source byte valid |
| ent_byte | input | 8 | Source byte |

## Verification
A wrong on/off flag shows up in bit 0 of the control byte one cycle after the next read of address 0. Its effect on capture shows as a ready flag that rises or fails to rise on the address 1 read that follows a source strobe. A slot that does not empty, or that takes a byte while full, shows within two reads: a ready flag that stays 1 after a data read, or a data value that differs from the first byte offered to an empty slot. A byte that survives a switch-off shows on the first read of address 2 after it.

// File: rtl/rng_regwin_pkg.sv
package rng_regwin_pkg;
  localparam int RW_ADDR_W = 2;
  localparam int RW_BYTE_W = 8;

  typedef enum logic [RW_ADDR_W-1:0] {
    OFS_CTRL  = 2'd0,
    OFS_READY = 2'd1,
    OFS_DATA  = 2'd2
  } rw_ofs_e;

  localparam int BIT_ON      = 0;
  localparam int BIT_FITTED  = 6;
  localparam int BIT_READY   = 0;
endpackage

// File: rtl/rng_lfsr_src.sv
// Stand-in byte source: Galois LFSR, advances one step per adv pulse.
module rng_lfsr_src #(
  parameter int          LFSR_W = 16,
  parameter int          OUT_W  = 8,
  parameter logic [15:0] TAPS   = 16'hB400,
  parameter logic [15:0] SEED   = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [OUT_W-1:0] byte_o
);
  logic [LFSR_W-1:0] state_q;

  always_ff @(posedge clk) begin
    if (rst) state_q <= SEED[LFSR_W-1:0];
    else if (adv) begin
      if (state_q[0]) state_q <= (state_q >> 1) ^ TAPS[LFSR_W-1:0];
      else            state_q <= state_q >> 1;
    end
  end

  assign byte_o = state_q[OUT_W-1:0];
endmodule

// File: rtl/rng_onoff.sv
// On/off flag; flags a switch-off so the slot can be emptied.
module rng_onoff (
  input  logic clk,
  input  logic rst,
  input  logic wr_hit,
  input  logic wr_bit,
  output logic on_q,
  output logic turn_off
);
  always_ff @(posedge clk) begin
    if (rst)         on_q <= 1'b0;
    else if (wr_hit) on_q <= wr_bit;
  end

  assign turn_off = wr_hit && !wr_bit;
endmodule

// File: rtl/rng_slot.sv
// One-byte holding slot with ready flag.
module rng_slot #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              on_q,
  input  logic              turn_off,
  input  logic              take,
  input  logic              src_valid,
  input  logic [BYTE_W-1:0] src_byte,
  output logic              rdy_q,
  output logic [BYTE_W-1:0] data_q
);
  always_ff @(posedge clk) begin
    if (rst || turn_off) begin
      rdy_q  <= 1'b0;
      data_q <= '0;
    end else if (take) begin
      rdy_q  <= 1'b0;
    end else if (on_q && !rdy_q && src_valid) begin
      rdy_q  <= 1'b1;
      data_q <= src_byte;
    end
  end
endmodule

// File: rtl/rng_rdport.sv
// Registered read multiplexer for the register window.
module rng_rdport
  import rng_regwin_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic              on_q,
  input  logic              rdy_q,
  input  logic [BYTE_W-1:0] data_q,
  output logic [BYTE_W-1:0] rdata
);
  logic [BYTE_W-1:0] ctrl_b;
  logic [BYTE_W-1:0] ready_b;
  logic [BYTE_W-1:0] mux_d;

  for (genvar i = 0; i < BYTE_W; i++) begin : g_bits
    if (i == BIT_ON)          begin : g_on  assign ctrl_b[i] = on_q; end
    else if (i == BIT_FITTED) begin : g_fit assign ctrl_b[i] = 1'b1; end
    else                      begin : g_z   assign ctrl_b[i] = 1'b0; end
    if (i == BIT_READY)       begin : g_rdy assign ready_b[i] = rdy_q; end
    else                      begin : g_rz  assign ready_b[i] = 1'b0; end
  end

  always_comb begin
    case (addr)
      OFS_CTRL:  mux_d = ctrl_b;
      OFS_READY: mux_d = ready_b;
      OFS_DATA:  mux_d = data_q;
      default:   mux_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= mux_d;
  end
endmodule

// File: rtl/rng_regwin.sv
module rng_regwin
  import rng_regwin_pkg::*;
#(
  parameter int BYTE_W = RW_BYTE_W,
  parameter int ADDR_W = RW_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              ent_valid,
  input  logic [BYTE_W-1:0] ent_byte
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);

  logic              on_q;
  logic              turn_off;
  logic              rdy_q;
  logic [BYTE_W-1:0] data_q;
  logic              ctrl_wr;
  logic              take;

  assign ctrl_wr = bus_we && (bus_addr == A_CTRL);
  assign take    = bus_re && (bus_addr == A_DATA);

  rng_onoff u_onoff (
    .clk      (clk),
    .rst      (rst),
    .wr_hit   (ctrl_wr),
    .wr_bit   (bus_wdata[BIT_ON]),
    .on_q     (on_q),
    .turn_off (turn_off)
  );

  rng_slot #(.BYTE_W(BYTE_W)) u_slot (
    .clk       (clk),
    .rst       (rst),
    .on_q      (on_q),
    .turn_off  (turn_off),
    .take      (take),
    .src_valid (ent_valid),
    .src_byte  (ent_byte),
    .rdy_q     (rdy_q),
    .data_q    (data_q)
  );

  rng_rdport #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_rd (
    .clk    (clk),
    .rst    (rst),
    .rd     (bus_re),
    .addr   (bus_addr),
    .on_q   (on_q),
    .rdy_q  (rdy_q),
    .data_q (data_q),
    .rdata  (bus_rdata)
  );
endmodule

// File: rtl/rng_regwin_chk.sv
module rng_regwin_chk #(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BYTE_W-1:0] bus_wdata,
  input logic              bus_we,
  input logic              bus_re,
  input logic [BYTE_W-1:0] bus_rdata,
  input logic              ent_valid,
  input logic [BYTE_W-1:0] ent_byte,
  input logic              on_q,
  input logic              rdy_q,
  input logic [BYTE_W-1:0] data_q
);
  logic rd_data, off_wr;
  assign rd_data = bus_re && (bus_addr == 2'd2);
  assign off_wr  = bus_we && (bus_addr == 2'd0) && !bus_wdata[0];

  assert_rdata_holds_R1: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> $stable(bus_rdata));

  assert_ctrl_read_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_re && bus_addr == 2'd0) |=> (bus_rdata[6] && bus_rdata[0] == $past(on_q)));

  assert_capture_R4: assert property (@(posedge clk) disable iff (rst)
    (on_q && !rdy_q && ent_valid && !off_wr && !rd_data) |=> (rdy_q && data_q == $past(ent_byte)));

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (rdy_q && !rd_data && !off_wr) |=> (rdy_q && $stable(data_q)));

  assert_take_R7: assert property (@(posedge clk) disable iff (rst)
    rd_data |=> (!rdy_q && bus_rdata == $past(data_q)));

  assert_off_not_ready_R8: assert property (@(posedge clk) disable iff (rst)
    !on_q |-> !rdy_q);

  assert_off_clears_R8: assert property (@(posedge clk) disable iff (rst)
    off_wr |=> (!rdy_q && data_q == '0));
endmodule

bind rng_regwin rng_regwin_chk #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_we    (bus_we),
  .bus_re    (bus_re),
  .bus_rdata (bus_rdata),
  .ent_valid (ent_valid),
  .ent_byte  (ent_byte),
  .on_q      (on_q),
  .rdy_q     (rdy_q),
  .data_q    (data_q)
);

// File: tb/rng_regwin_tb_top.sv
module rng_regwin_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 29;

  typedef struct packed {
    logic       we;
    logic       re;
    logic [1:0] a;
    logic [7:0] wd;
    logic       ev;
    logic [7:0] eb;
    logic       chk;
    logic [7:0] exp;
  } vec_t;

  // Rows are one cycle each; chk rows compare bus_rdata after the edge.
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b1,2'd0,8'h00,1'b0,8'h00,1'b1,8'h40}, // 0  R2 fitted, off
    '{1'b0,1'b0,2'd0,8'h00,1'b1,8'hA5,1'b0,8'h00}, // 1  byte while off
    '{1'b0,1'b1,2'd1,8'h00,1'b0,8'h00,1'b1,8'h00}, // 2  R8 not captured
    '{1'b1,1'b0,2'd0,8'hFE,1'b0,8'h00,1'b0,8'h00}, // 3  write bit0=0
    '{1'b0,1'b1,2'd0,8'h00,1'b0,8'h00,1'b1,8'h40}, // 4  R3 other bits ignored
    '{1'b1,1'b0,2'd0,8'h01,1'b0,8'h00,1'b0,8'h00}, // 5  switch on
    '{1'b0,1'b1,2'd0,8'h00,1'b0,8'h00,1'b1,8'h41}, // 6  R3 reads back on
    '{1'b0,1'b0,2'd0,8'h00,1'b1,8'h3C,1'b0,8'h00}, // 7  capture 3C
    '{1'b0,1'b1,2'd1,8'h00,1'b0,8'h00,1'b1,8'h01}, // 8  R4 ready
    '{1'b0,1'b0,2'd0,8'h00,1'b1,8'h77,1'b0,8'h00}, // 9  extra byte while full
    '{1'b0,1'b1,2'd1,8'h00,1'b0,8'h00,1'b1,8'h01}, // 10 R6 poll
    '{1'b0,1'b1,2'd1,8'h00,1'b0,8'h00,1'b1,8'h01}, // 11 R6 poll again
    '{1'b0,1'b1,2'd2,8'h00,1'b0,8'h00,1'b1,8'h3C}, // 12 R5 R7 first byte kept
    '{1'b0,1'b1,2'd1,8'h00,1'b0,8'h00,1'b1,8'h00}, // 13 R7 ready cleared
    '{1'b1,1'b0,2'd2,8'h55,1'b0,8'h00,1'b0,8'h00}, // 14 write to data
    '{1'b0,1'b1,2'd1,8'h00,1'b0,8'h00,1'b1,8'h00}, // 15 R9 no effect
    '{1'b0,1'b0,2'd0,8'h00,1'b1,8'hC3,1'b0,8'h00}, // 16 capture C3
    '{1'b1,1'b0,2'd1,8'h00,1'b0,8'h00,1'b0,8'h00}, // 17 write to ready
    '{1'b0,1'b1,2'd2,8'h00,1'b0,8'h00,1'b1,8'hC3}, // 18 R9 byte intact
    '{1'b0,1'b1,2'd3,8'h00,1'b0,8'h00,1'b1,8'h00}, // 19 R1 unmapped
    '{1'b0,1'b0,2'd0,8'h00,1'b1,8'h9A,1'b0,8'h00}, // 20 capture 9A
    '{1'b0,1'b1,2'd2,8'h00,1'b1,8'h11,1'b1,8'h9A}, // 21 R7 take with arrival
    '{1'b0,1'b1,2'd1,8'h00,1'b0,8'h00,1'b1,8'h00}, // 22 R7 arrival dropped
    '{1'b0,1'b1,2'd2,8'h00,1'b0,8'h00,1'b1,8'h9A}, // 23 R7 byte kept
    '{1'b0,1'b0,2'd0,8'h00,1'b1,8'hE1,1'b0,8'h00}, // 24 capture E1
    '{1'b1,1'b0,2'd0,8'h00,1'b0,8'h00,1'b0,8'h00}, // 25 switch off
    '{1'b0,1'b1,2'd2,8'h00,1'b0,8'h00,1'b1,8'h00}, // 26 R8 byte zeroed
    '{1'b0,1'b1,2'd1,8'h00,1'b0,8'h00,1'b1,8'h00}, // 27 R8 not ready
    '{1'b0,1'b1,2'd0,8'h00,1'b0,8'h00,1'b1,8'h40}  // 28 R2 after writing 00
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       we = 1'b0, re = 1'b0, ev = 1'b0;
  logic [7:0] eb_drv = '0;
  logic       use_lfsr = 1'b0, adv = 1'b0;
  logic [7:0] lfsr_byte, ent_b, rdata;
  int         checks = 0, errors = 0;
  bit         done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign ent_b = use_lfsr ? lfsr_byte : eb_drv;

  rng_lfsr_src u_src (.clk(clk), .rst(rst), .adv(adv), .byte_o(lfsr_byte));

  rng_regwin dut_i (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wdata(wdata),
    .bus_we(we), .bus_re(re), .bus_rdata(rdata),
    .ent_valid(ev), .ent_byte(ent_b)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle();
    we = 0; re = 0; ev = 0; adv = 0; addr = 0; wdata = 0; eb_drv = 0;
  endtask

  task automatic rd(input logic [1:0] a, input string req, input logic [7:0] exp);
    idle(); re = 1; addr = a; step(); re = 0; check(req, rdata, exp);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    idle(); we = 1; addr = a; wdata = d; step(); we = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); step(); step();
    rst = 0;
    check("R10 rdata after reset", rdata, 8'h00);
    for (int i = 0; i < NV; i++) begin
      we = VECS[i].we; re = VECS[i].re; addr = VECS[i].a; wdata = VECS[i].wd;
      ev = VECS[i].ev; eb_drv = VECS[i].eb;
      step();
      if (VECS[i].chk) check($sformatf("R1 row %0d", i), rdata, VECS[i].exp);
    end
    idle();

    // LFSR-fed stream: one byte per round, R4 and R7
    use_lfsr = 1;
    wr(2'd0, 8'h01);
    for (int k = 0; k < 8; k++) begin
      logic [7:0] want;
      idle(); ev = 1; adv = 1; want = lfsr_byte; step();
      idle(); adv = 1; step();
      rd(2'd1, "R4 stream ready", 8'h01);
      rd(2'd2, "R7 stream byte", want);
      rd(2'd1, "R7 stream cleared", 8'h00);
    end
    use_lfsr = 0;

    // Reset with a byte held: R10
    idle(); ev = 1; eb_drv = 8'h5A; step(); idle();
    rd(2'd1, "R4 before reset", 8'h01);
    rst = 1; step(); rst = 0;
    check("R10 rdata cleared", rdata, 8'h00);
    rd(2'd0, "R10 off", 8'h40);
    rd(2'd1, "R10 not ready", 8'h00);
    rd(2'd2, "R10 data zero", 8'h00);
    idle(); ev = 1; eb_drv = 8'h66; step(); idle();
    rd(2'd1, "R8 no capture after reset", 8'h00);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule